// File: doc/BRIEF.md
# Calendar-Driven FIFO Status Sequencer

This block decides which logical port's FIFO status goes out in each slot of a packet interface's status channel. Two calendars, each holding 256 port numbers, are stored in the block, and the host fills them through a small write/read port. A select input chooses which calendar drives the sequence. On every status slot the sequencer reads the next calendar entry and presents that port number with the port's 2-bit fill status. The status comes from a status vector that is an input to the block.

A port that needs fast updates is written into several calendar entries, so it gets that many slots in every pass. A change of calendar takes effect only when a pass ends, which means no pass ever mixes entries from the two calendars. While the interface is disabled the sequencer waits at entry 0 and produces nothing.

Top module: `statusCalSeq`

## Requirements
- R1: After reset every entry of both calendars reads 0xFF, and `seqValid` is low.
- R2: When `hostWe` is high, `hostWdata` is written on the clock edge. `hostAddr[8]` picks the calendar (0 or 1) and `hostAddr[7:0]` picks the entry. When `hostRe` is high, the addressed entry appears on `hostRdata` one cycle later and then holds until the next read. A write to one calendar leaves the other calendar unchanged.
- R3: Each slot taken while enabled uses the next entry in ascending order, starting at 0. After entry 255 the sequence continues at entry 0.
- R4: `seqValid` is high for exactly one cycle, the cycle that follows each `slotTick` sampled while enabled. It is low at every other time.
- R5: `seqStatus` is bits [2p+1:2p] of `portStatus`, where p is the emitted port number. The vector is sampled in the same cycle as the tick.
- R6: `calSel` is taken up only after entry 255 has been used, or while the block is disabled. A change part-way through a pass does not alter the rest of that pass.
- R7: While `enable` is low, ticks produce no output and the position is held at entry 0. After re-enabling, the first slot uses entry 0 of the calendar that `calSel` selected while the block was disabled.
- R8: A port written into N entries of the active calendar is emitted exactly N times in one full 256-slot pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Interface enable; low holds the sequencer idle at entry 0 |
| calSel | input | 1 | Calendar choice, taken up at the end of a pass |
| slotTick | input | 1 | One status slot is due |
| portStatus | input | 512 | 2-bit status for each of the 256 ports; port p is at bits [2p+1:2p] |
| hostWe | input | 1 | Host write strobe |
| hostRe | input | 1 | Host read strobe |
| hostAddr | input | 9 | Bit 8 is the calendar, bits 7:0 are the entry |
| hostWdata | input | 8 | Port number to store |
| hostRdata | output | 8 | Entry read back, one cycle after `hostRe` |
| seqValid | output | 1 | A slot result is present |
| seqPort | output | 8 | Port number for this slot |
| seqStatus | output | 2 | Status of that port |

## Verification
The assertions assume that `slotTick` is a single-cycle strobe. They also assume that the host does not write the entry being sequenced in the same cycle as a tick, because the emitted value would then depend on the read-before-write order. The stimulus keeps to these assumptions in three ways. It programs the calendars before enabling. It drives every input only at falling edges. It changes `calSel` and `portStatus` only between ticks, so the value the design samples is always the one the scoreboard used.

// File: rtl/calSeqPkg.sv
package calSeqPkg;
  localparam int IDX_W  = 8;
  localparam int PORT_W = 8;
  localparam int STAT_W = 2;

  // strobes from the sequencing control to the calendar datapath
  typedef struct packed {
    logic             step;   // consume one entry this cycle
    logic             clear;  // interface disabled
    logic [IDX_W-1:0] entry;  // entry being consumed
    logic             bank;   // calendar in use
  } seqStrobes_t;
endpackage

// File: rtl/seqCtrl.sv
module seqCtrl
  import calSeqPkg::*;
#(
  parameter int IW = IDX_W
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        enable,
  input  logic        calSel,
  input  logic        slotTick,
  output seqStrobes_t strobes
);
  localparam logic [IW-1:0] LAST = '1;

  logic [IW-1:0] idx;
  logic          activeSel;
  logic          step;
  logic          passEnd;

  assign step    = enable & slotTick;
  assign passEnd = step & (idx == LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idx       <= '0;
      activeSel <= 1'b0;
    end else if (!enable) begin
      idx       <= '0;
      activeSel <= calSel;
    end else if (step) begin
      idx <= idx + 1'b1;
      if (passEnd) activeSel <= calSel;
    end
  end

  always_comb begin
    strobes.step  = step;
    strobes.clear = ~enable;
    strobes.entry = idx;
    strobes.bank  = activeSel;
  end

  a_r3_index_advance: assert property (@(posedge clk) disable iff (!rstN)
    (step && idx != LAST) |=> idx == $past(idx) + 1'b1);
  a_r3_index_wraps: assert property (@(posedge clk) disable iff (!rstN)
    (step && idx == LAST) |=> idx == '0);
  a_r7_idle_at_zero: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> idx == '0);
  a_r6_bank_held_in_pass: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !(step && idx == LAST)) |=> $stable(activeSel));
endmodule

// File: rtl/calDatapath.sv
module calDatapath
  import calSeqPkg::*;
#(
  parameter int IW = IDX_W,
  parameter int PW = PORT_W,
  parameter int SW = STAT_W
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  seqStrobes_t             strobes,
  input  logic [(1<<PW)*SW-1:0]   portStatus,
  input  logic                    hostWe,
  input  logic                    hostRe,
  input  logic [IW:0]             hostAddr,
  input  logic [PW-1:0]           hostWdata,
  output logic [PW-1:0]           hostRdata,
  output logic                    seqValid,
  output logic [PW-1:0]           seqPort,
  output logic [SW-1:0]           seqStatus
);
  localparam int DEPTH  = 1 << IW;
  localparam int NBANKS = 2;

  logic [PW-1:0] seqRd  [NBANKS];
  logic [PW-1:0] hostRd [NBANKS];
  logic [PW-1:0] curPort;

  for (genvar b = 0; b < NBANKS; b++) begin : gBank
    logic [PW-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (!rstN) begin
        for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
      end else if (hostWe && hostAddr[IW] == 1'(b)) begin
        mem[hostAddr[IW-1:0]] <= hostWdata;
      end
    end
    assign seqRd[b]  = mem[strobes.entry];
    assign hostRd[b] = mem[hostAddr[IW-1:0]];
  end

  assign curPort = seqRd[strobes.bank];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      seqValid  <= 1'b0;
      seqPort   <= '0;
      seqStatus <= '0;
      hostRdata <= '0;
    end else begin
      seqValid <= strobes.step;
      if (strobes.clear) begin
        seqPort   <= '0;
        seqStatus <= '0;
      end else if (strobes.step) begin
        seqPort   <= curPort;
        seqStatus <= portStatus[curPort*SW +: SW];
      end
      if (hostRe) hostRdata <= hostRd[hostAddr[IW]];
    end
  end

  a_r4_valid_after_step: assert property (@(posedge clk) disable iff (!rstN)
    strobes.step |=> seqValid);
  a_r4_no_stray_valid: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.step |=> !seqValid);
  a_r7_quiet_when_off: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clear |=> (seqPort == '0 && seqStatus == '0));
  a_r2_rdata_holds: assert property (@(posedge clk) disable iff (!rstN)
    !hostRe |=> $stable(hostRdata));
endmodule

// File: rtl/statusCalSeq.sv
module statusCalSeq
  import calSeqPkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          enable,
  input  logic                          calSel,
  input  logic                          slotTick,
  input  logic [(1<<PORT_W)*STAT_W-1:0] portStatus,
  input  logic                          hostWe,
  input  logic                          hostRe,
  input  logic [IDX_W:0]                hostAddr,
  input  logic [PORT_W-1:0]             hostWdata,
  output logic [PORT_W-1:0]             hostRdata,
  output logic                          seqValid,
  output logic [PORT_W-1:0]             seqPort,
  output logic [STAT_W-1:0]             seqStatus
);
  seqStrobes_t strobes;

  seqCtrl #(.IW(IDX_W)) uCtrl (
    .clk(clk), .rstN(rstN), .enable(enable), .calSel(calSel),
    .slotTick(slotTick), .strobes(strobes)
  );

  calDatapath #(.IW(IDX_W), .PW(PORT_W), .SW(STAT_W)) uData (
    .clk(clk), .rstN(rstN), .strobes(strobes), .portStatus(portStatus),
    .hostWe(hostWe), .hostRe(hostRe), .hostAddr(hostAddr),
    .hostWdata(hostWdata), .hostRdata(hostRdata), .seqValid(seqValid),
    .seqPort(seqPort), .seqStatus(seqStatus)
  );
endmodule

// File: tb/statusCalSeq_test.sv
`timescale 1ns/1ps
module statusCalSeq_test;
  localparam logic [7:0] HOT = 8'h01;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         enable = 1'b0;
  logic         calSel = 1'b0;
  logic         slotTick = 1'b0;
  logic [511:0] portStatus = '0;
  logic         hostWe = 1'b0;
  logic         hostRe = 1'b0;
  logic [8:0]   hostAddr = '0;
  logic [7:0]   hostWdata = '0;
  logic [7:0]   hostRdata;
  logic         seqValid;
  logic [7:0]   seqPort;
  logic [1:0]   seqStatus;

  statusCalSeq uut (.*);

  always #2.5 clk = ~clk;

  typedef struct { logic [7:0] port; logic [1:0] st; } expItem_t;
  expItem_t   expQ[$];
  logic [7:0] modelCal [2][256];
  int  mIdx = 0;
  bit  mBank = 0;
  int  vecs = 0, errs = 0, cycles = 0, hotSeen = 0;
  bit  countHot = 0;

  task automatic chk(string req, bit ok, int act, int exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      errs++;
      $display("FAIL R4 watchdog actual %0d expected below 50000", cycles);
      summary();
      $finish;
    end
  end

  // monitor: pops the scoreboard whenever the design reports a slot
  always @(negedge clk) begin
    if (rstN && seqValid) begin
      if (expQ.size() == 0) begin
        chk("R4 unexpected seqValid", 1'b0, 1, 0);
      end else begin
        expItem_t e;
        e = expQ.pop_front();
        chk("R3 seqPort", seqPort == e.port, seqPort, e.port);
        chk("R5 seqStatus", seqStatus == e.st, seqStatus, e.st);
        if (countHot && seqPort == HOT) hotSeen++;
      end
    end
  end

  function automatic logic [1:0] stOf(logic [7:0] p);
    return portStatus[p*2 +: 2];
  endfunction

  // driver: predicts the slot result, then issues the tick
  task automatic tick();
    if (enable) begin
      expItem_t e;
      e.port = modelCal[mBank][mIdx];
      e.st   = stOf(e.port);
      expQ.push_back(e);
      if (mIdx == 255) begin
        mIdx  = 0;
        mBank = calSel;
      end else mIdx++;
    end
    slotTick = 1'b1;
    @(negedge clk);
    slotTick = 1'b0;
  endtask

  task automatic hostWrite(bit bank, int ent, logic [7:0] d);
    hostWe = 1'b1; hostAddr = {bank, 8'(ent)}; hostWdata = d;
    @(negedge clk);
    hostWe = 1'b0;
    modelCal[bank][ent] = d;
  endtask

  task automatic hostRead(bit bank, int ent, logic [7:0] exp, string req);
    hostRe = 1'b1; hostAddr = {bank, 8'(ent)};
    @(negedge clk);
    hostRe = 1'b0;
    chk(req, hostRdata == exp, hostRdata, exp);
  endtask

  task automatic setStatus(int salt);
    for (int p = 0; p < 256; p++) portStatus[p*2 +: 2] = 2'((p + p/4 + salt) % 4);
  endtask

  initial begin
    for (int b = 0; b < 2; b++)
      for (int i = 0; i < 256; i++) modelCal[b][i] = 8'hFF;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1 seqValid after reset", seqValid == 1'b0, seqValid, 0);
    hostRead(0, 0, 8'hFF, "R1 cal0[0] reset");
    hostRead(0, 255, 8'hFF, "R1 cal0[255] reset");
    hostRead(1, 7, 8'hFF, "R1 cal1[7] reset");

    // program: cal0 holds HOT in half the entries, cal1 counts down
    for (int i = 0; i < 256; i++) hostWrite(0, i, (i % 8 < 4) ? HOT : 8'(i));
    hostRead(1, 0, 8'hFF, "R2 cal1 untouched by cal0 writes");
    for (int i = 0; i < 256; i++) hostWrite(1, i, 8'(255 - i));
    hostRead(0, 5, 8'h05, "R2 cal0[5]");
    hostRead(0, 3, HOT, "R2 cal0[3]");
    hostRead(1, 200, 8'd55, "R2 cal1[200]");
    hostRead(0, 255, 8'hFF, "R2 cal0[255] kept after cal1 writes");

    setStatus(0);
    calSel = 1'b0;
    enable = 1'b1;
    @(negedge clk);
    mIdx = 0; mBank = calSel;

    // R3/R6/R8: one full pass, select flips part-way
    hotSeen = 0; countHot = 1;
    for (int t = 0; t < 256; t++) begin
      if (t == 100) calSel = 1'b1;
      tick();
    end
    @(negedge clk);
    countHot = 0;
    chk("R8 HOT slots per pass", hotSeen == 128, hotSeen, 128);

    // R6: next pass runs from cal1, ticks with gaps (R4)
    for (int t = 0; t < 20; t++) begin
      tick();
      if (t % 3 == 0) @(negedge clk);
    end

    // R5: status vector changed between ticks
    setStatus(3);
    for (int t = 0; t < 6; t++) tick();
    @(negedge clk);

    // R7: disabled ticks do nothing
    enable = 1'b0;
    @(negedge clk);
    for (int t = 0; t < 8; t++) tick();
    @(negedge clk);
    chk("R7 no output while disabled", seqValid == 1'b0, seqValid, 0);
    chk("R7 scoreboard drained", expQ.size() == 0, expQ.size(), 0);
    calSel = 1'b0;
    @(negedge clk);
    enable = 1'b1;
    @(negedge clk);
    mIdx = 0; mBank = calSel;
    for (int t = 0; t < 10; t++) tick();

    repeat (3) @(negedge clk);
    chk("R4 every predicted slot seen", expQ.size() == 0, expQ.size(), 0);
    chk("R4 valid low when idle", seqValid == 1'b0, seqValid, 0);
    summary();
    $finish;
  end
endmodule